// File: doc/BRIEF.md
# Nested Power Domain State Monitor

This block watches the supply states of two nested power domains and reports which named power state each domain is in. An inner (child) domain and an outer (parent) domain each have a primary supply and a retention supply. Each supply reports a 2-bit state code. The child's state comes from its own two supplies. The parent's state comes from its own supplies and is also qualified by the child's decoded state. A composite view merges the two domains into one state.

Any combination that matches no named state raises a combinational illegal flag in the same cycle. On the next clock edge it also sets a sticky error bit. That bit stays set until a synchronous clear pulse or the active-low reset removes it.

A refined mode input switches to a stricter rule set. In that mode retention is forbidden, and an active-low power-up control decides whether both domains must be running (control low) or off (control high). The block is meant to sit beside a power controller as a monitor. It drives nothing in the power network.

Top module: `pwr_state_monitor`

## Requirements
- R1: Supply codes are 00 = off, 01 = on at low voltage, 10 = on at full voltage, 11 = reserved. Both 01 and 10 count as "on". A reserved code on any of the four supply inputs always makes `illegal` high.
- R2: Domain state codes are 00 = OFF, 01 = RET, 10 = RUN, 11 = NONE (no named state). In the default mode the child is RUN when both its supplies are on, RET when its primary is off and its retention is on, and OFF when both are off. Every other combination gives NONE.
- R3: In the default mode the parent is RUN whenever both of its supplies are on, whatever state the child is in.
- R4: In the default mode the parent is RET only when its primary is off, its retention is on, and the child is RET or OFF. With a RUN or NONE child that supply pattern gives NONE.
- R5: The parent is OFF only when both of its supplies are off and the child is OFF.
- R6: `illegal` is high in the same cycle, combinationally, exactly when the child or the parent state is NONE.
- R7: In refined mode (`refined_mode` = 1) no domain reports RET. A domain reports RUN only when both its supplies are on and `pwrup_n` = 0. It reports OFF only when both its supplies are off and `pwrup_n` = 1 (for the parent, the child must also be OFF). Otherwise it reports NONE.
- R8: The composite state is RUN when both domains are RUN, OFF when both are OFF, and otherwise 11 (mixed). A mixed composite state does not by itself raise `illegal`.
- R9: If `illegal` is high at a clock edge, `err_sticky` is high after that edge. When `illegal` and `err_clr` are both high in the same cycle, the set wins.
- R10: `err_sticky` holds its value until a cycle in which `err_clr` is high and `illegal` is low. After that edge it is low.
- R11: While `rst_n` is low, `err_sticky` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| refined_mode | input | 1 | 1 selects the refined rule set (no retention) |
| pwrup_n | input | 1 | Active-low power-up control, used in refined mode |
| child_prim | input | 2 | Child primary supply code |
| child_ret | input | 2 | Child retention supply code |
| par_prim | input | 2 | Parent primary supply code |
| par_ret | input | 2 | Parent retention supply code |
| err_clr | input | 1 | Synchronous clear of the sticky error |
| child_state | output | 2 | Decoded child state |
| par_state | output | 2 | Decoded parent state |
| comp_state | output | 2 | Composite state of both domains |
| illegal | output | 1 | No named state for some domain, this cycle |
| err_sticky | output | 1 | Latched record of any illegal cycle |

## Verification
The assertions check the following on every cycle:
- a reserved code always raises the flag;
- a parent in RET or OFF always has a permitted child state;
- refined mode never shows RET;
- a composite RUN always has two running domains;
- the sticky bit sets, holds and clears as its rules require.

Only the bench's scenarios can show that each named state is actually reached from its supply pattern, that NONE appears for each forbidden pattern, and that set beats clear in the same cycle. For that the bench sweeps every supply, mode and control combination against its own model.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
    localparam int SUP_W = 2;
    localparam int N_SUP = 4;

    localparam logic [SUP_W-1:0] SUP_OFF   = 2'b00;
    localparam logic [SUP_W-1:0] SUP_ON_LO = 2'b01;
    localparam logic [SUP_W-1:0] SUP_ON_HI = 2'b10;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_RET  = 2'b01,
        ST_RUN  = 2'b10,
        ST_NONE = 2'b11
    } dom_state_t;

    typedef struct packed {
        logic err;
    } err_reg_t;
endpackage

// File: rtl/psm_supply_class.sv
module psm_supply_class #(
    parameter int SW = 2
) (
    input  logic [SW-1:0] code,
    output logic          is_on,
    output logic          is_off
);
    import pwr_state_pkg::*;

    always_comb begin
        is_off = (code == SW'(SUP_OFF));
        is_on  = (code == SW'(SUP_ON_LO)) || (code == SW'(SUP_ON_HI));
    end
endmodule

// File: rtl/psm_dom_decode.sv
module psm_dom_decode (
    input  logic prim_on,
    input  logic prim_off,
    input  logic ret_on,
    input  logic ret_off,
    input  logic refined,
    input  logic pwrup_n,
    input  logic ret_ok,
    input  logic off_ok,
    output pwr_state_pkg::dom_state_t st
);
    import pwr_state_pkg::*;

    dom_state_t base_st;

    // Default rule set: retention allowed, qualifiers from the inner domain.
    always_comb begin
        base_st = ST_NONE;
        if (prim_on && ret_on)
            base_st = ST_RUN;
        else if (prim_off && ret_on && ret_ok)
            base_st = ST_RET;
        else if (prim_off && ret_off && off_ok)
            base_st = ST_OFF;
    end

    // Refined rule set: no retention, control input dictates RUN or OFF.
    always_comb begin
        if (!refined)
            st = base_st;
        else if (base_st == ST_RUN && !pwrup_n)
            st = ST_RUN;
        else if (base_st == ST_OFF && pwrup_n)
            st = ST_OFF;
        else
            st = ST_NONE;
    end
endmodule

// File: rtl/psm_err_latch.sv
module psm_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic illegal,
    output logic err
);
    import pwr_state_pkg::*;

    err_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr)
            r_d.err = 1'b0;
        if (illegal)
            r_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign err = r_q.err;

    p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> err);
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
    p_sticky_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !illegal) |=> !err);
endmodule

// File: rtl/pwr_state_monitor.sv
module pwr_state_monitor #(
    parameter int SW = pwr_state_pkg::SUP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          refined_mode,
    input  logic          pwrup_n,
    input  logic [SW-1:0] child_prim,
    input  logic [SW-1:0] child_ret,
    input  logic [SW-1:0] par_prim,
    input  logic [SW-1:0] par_ret,
    input  logic          err_clr,
    output logic [1:0]    child_state,
    output logic [1:0]    par_state,
    output logic [1:0]    comp_state,
    output logic          illegal,
    output logic          err_sticky
);
    import pwr_state_pkg::*;

    localparam int NS = N_SUP;
    localparam int I_CP = 0;
    localparam int I_CR = 1;
    localparam int I_PP = 2;
    localparam int I_PR = 3;

    logic [SW-1:0] codes  [NS];
    logic [NS-1:0] sup_on;
    logic [NS-1:0] sup_off;

    assign codes[I_CP] = child_prim;
    assign codes[I_CR] = child_ret;
    assign codes[I_PP] = par_prim;
    assign codes[I_PR] = par_ret;

    for (genvar g = 0; g < NS; g++) begin : g_sup
        psm_supply_class #(.SW(SW)) u_cls (
            .code   (codes[g]),
            .is_on  (sup_on[g]),
            .is_off (sup_off[g])
        );
    end

    dom_state_t child_st, par_st, comp_st;
    logic       par_ret_ok, par_off_ok;

    psm_dom_decode u_child (
        .prim_on  (sup_on[I_CP]),
        .prim_off (sup_off[I_CP]),
        .ret_on   (sup_on[I_CR]),
        .ret_off  (sup_off[I_CR]),
        .refined  (refined_mode),
        .pwrup_n  (pwrup_n),
        .ret_ok   (1'b1),
        .off_ok   (1'b1),
        .st       (child_st)
    );

    always_comb begin
        par_ret_ok = (child_st == ST_RET) || (child_st == ST_OFF);
        par_off_ok = (child_st == ST_OFF);
    end

    psm_dom_decode u_parent (
        .prim_on  (sup_on[I_PP]),
        .prim_off (sup_off[I_PP]),
        .ret_on   (sup_on[I_PR]),
        .ret_off  (sup_off[I_PR]),
        .refined  (refined_mode),
        .pwrup_n  (pwrup_n),
        .ret_ok   (par_ret_ok),
        .off_ok   (par_off_ok),
        .st       (par_st)
    );

    always_comb begin
        if (child_st == ST_RUN && par_st == ST_RUN)
            comp_st = ST_RUN;
        else if (child_st == ST_OFF && par_st == ST_OFF)
            comp_st = ST_OFF;
        else
            comp_st = ST_NONE;
    end

    logic ill_now;
    assign ill_now = (child_st == ST_NONE) || (par_st == ST_NONE);

    psm_err_latch u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (err_clr),
        .illegal (ill_now),
        .err     (err_sticky)
    );

    assign child_state = child_st;
    assign par_state   = par_st;
    assign comp_state  = comp_st;
    assign illegal     = ill_now;

    p_rsv_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((&child_prim) || (&child_ret) || (&par_prim) || (&par_ret)) |-> illegal);
    p_child_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (child_state == 2'b01) |-> (child_prim == 2'b00 && child_ret != 2'b00 && child_ret != 2'b11));
    p_par_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!refined_mode && (par_prim == 2'b01 || par_prim == 2'b10) &&
         (par_ret == 2'b01 || par_ret == 2'b10)) |-> (par_state == 2'b10));
    p_par_ret_child_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (par_state == 2'b01) |-> (child_state == 2'b01 || child_state == 2'b00));
    p_par_off_child_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_state == 2'b00) |-> (child_state == 2'b00));
    p_no_ret_refined_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refined_mode |-> (child_state != 2'b01 && par_state != 2'b01));
    p_comp_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_state == 2'b10) |-> (child_state == 2'b10 && par_state == 2'b10));
endmodule

// File: tb/pwr_state_monitor_test.sv
module pwr_state_monitor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refined_mode = 1'b0, pwrup_n = 1'b0, err_clr = 1'b0;
    logic [1:0] child_prim = 2'b00, child_ret = 2'b00, par_prim = 2'b00, par_ret = 2'b00;
    logic [1:0] child_state, par_state, comp_state;
    logic illegal, err_sticky;

    int checks = 0;
    int errors = 0;
    int exp_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_state_monitor uut (
        .clk(clk), .rst_n(rst_n), .refined_mode(refined_mode), .pwrup_n(pwrup_n),
        .child_prim(child_prim), .child_ret(child_ret), .par_prim(par_prim),
        .par_ret(par_ret), .err_clr(err_clr), .child_state(child_state),
        .par_state(par_state), .comp_state(comp_state), .illegal(illegal),
        .err_sticky(err_sticky)
    );

    // Model encodings: 0 OFF, 1 RET, 2 RUN, 3 NONE / mixed.
    function automatic bit up(int c);
        return (c == 1) || (c == 2);
    endfunction

    function automatic int m_child(int p, int r, int md, int pn);
        if (md == 1) begin
            if (up(p) && up(r) && pn == 0) return 2;
            if (p == 0 && r == 0 && pn == 1) return 0;
            return 3;
        end
        if (up(p) && up(r)) return 2;
        if (p == 0 && up(r)) return 1;
        if (p == 0 && r == 0) return 0;
        return 3;
    endfunction

    function automatic int m_parent(int p, int r, int md, int pn, int c);
        if (md == 1) begin
            if (up(p) && up(r) && pn == 0) return 2;
            if (p == 0 && r == 0 && pn == 1 && c == 0) return 0;
            return 3;
        end
        if (up(p) && up(r)) return 2;
        if (p == 0 && up(r) && (c == 0 || c == 1)) return 1;
        if (p == 0 && r == 0 && c == 0) return 0;
        return 3;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive at the falling edge, check combinational outputs, clock, check sticky bit.
    task automatic step(string tag, int cp, int cr, int pp, int pr, int md, int pn, int clr);
        int ec, ep, ecm, eill;
        @(negedge clk);
        child_prim = 2'(cp); child_ret = 2'(cr); par_prim = 2'(pp); par_ret = 2'(pr);
        refined_mode = md[0]; pwrup_n = pn[0]; err_clr = clr[0];
        ec = m_child(cp, cr, md, pn);
        ep = m_parent(pp, pr, md, pn, ec);
        ecm = (ec == 2 && ep == 2) ? 2 : ((ec == 0 && ep == 0) ? 0 : 3);
        eill = (ec == 3 || ep == 3) ? 1 : 0;
        #1;
        chk({tag, " child"}, int'(child_state), ec);
        chk({tag, " parent"}, int'(par_state), ep);
        chk({tag, " comp R8"}, int'(comp_state), ecm);
        chk({tag, " illegal R6"}, int'(illegal), eill);
        @(posedge clk);
        if (eill == 1) exp_err = 1;
        else if (clr == 1) exp_err = 0;
        #1;
        chk({tag, " sticky R9/R10"}, int'(err_sticky), exp_err);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset sticky", int'(err_sticky), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Default mode named states
        step("R2 child RUN parent RUN", 2, 1, 2, 1, 0, 0, 0);
        step("R2 child RET", 0, 1, 0, 2, 0, 0, 0);
        step("R2 child OFF parent OFF R5", 0, 0, 0, 0, 0, 0, 0);
        step("R3 parent RUN child OFF", 0, 0, 1, 1, 0, 0, 0);
        step("R3 parent RUN child RET", 0, 2, 2, 2, 0, 0, 0);
        step("R4 parent RET child OFF", 0, 0, 0, 1, 0, 0, 0);
        step("R2 child illegal prim on ret off", 1, 0, 2, 2, 0, 0, 0);
        step("R10 sticky holds", 2, 2, 2, 2, 0, 0, 0);
        step("R10 sticky clear", 2, 2, 2, 2, 0, 0, 1);
        step("R4 parent RET child RUN", 2, 2, 0, 2, 0, 0, 0);
        step("R9 set wins over clear", 2, 2, 0, 2, 0, 0, 1);
        step("R10 clear after", 0, 0, 0, 0, 0, 0, 1);
        step("R5 parent OFF child RET", 0, 1, 0, 0, 0, 0, 0);
        step("R10 clear again", 0, 0, 0, 0, 0, 0, 1);
        // Reserved codes, one supply at a time
        step("R1 reserved child prim", 3, 2, 2, 2, 0, 0, 0);
        step("R1 reserved child ret", 2, 3, 2, 2, 0, 0, 0);
        step("R1 reserved parent prim", 2, 2, 3, 2, 0, 0, 0);
        step("R1 reserved parent ret", 2, 2, 2, 3, 0, 0, 1);
        step("R10 clear", 2, 2, 2, 2, 0, 0, 1);
        // Refined mode
        step("R7 refined RUN", 2, 1, 1, 2, 1, 0, 0);
        step("R7 refined RUN with pwrup_n high", 2, 1, 1, 2, 1, 1, 1);
        step("R7 refined OFF", 0, 0, 0, 0, 1, 1, 1);
        step("R7 refined OFF with pwrup_n low", 0, 0, 0, 0, 1, 0, 1);
        step("R7 refined RET forbidden", 0, 1, 0, 1, 1, 1, 1);
        step("R7 refined clear", 0, 0, 0, 0, 1, 1, 1);
        step("R8 mixed comp not illegal", 0, 1, 2, 2, 0, 0, 0);

        // R6 exhaustive sweep over all codes, modes and control values
        for (int v = 0; v < 1024; v++) begin
            step("R6 sweep", v & 3, (v >> 2) & 3, (v >> 4) & 3, (v >> 6) & 3,
                 (v >> 8) & 1, (v >> 9) & 1, (v % 5 == 0) ? 1 : 0);
        end

        // Reset mid-run drops the sticky bit
        step("R9 set before reset", 3, 3, 3, 3, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R11 async reset clears sticky", int'(err_sticky), 0);
        exp_err = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule